// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch is taken. Two component predictors run side by side. The local component keeps a 10-bit history of recent outcomes for each branch slot and uses it to pick a 2-bit counter. The global component uses one 12-bit history of the most recent resolved outcomes to pick a counter from a 4096-entry table. A third 4096-entry table of 2-bit counters is indexed by the same global history and decides which component supplies the final answer.

A lookup is purely combinational. The caller presents a branch address. It gets back the final direction, both component directions, the choice that was made, and the two table indices. When the branch resolves, the caller returns the address, the real outcome and the two indices it received. On the next clock edge the block trains both components and shifts both histories. It moves the chooser only when the two components predicted differently. Histories change only at resolve time, so there is no speculative history and nothing to repair.

Top module: `tourney_bp`

## Requirements
- R1: After reset every history is zero, every component counter holds 1 (so both components predict not-taken), and every chooser counter holds 2 (so the global component is selected).
- R2: Address bits [11:2] of `lk_pc` select one of 1024 local histories. That 10-bit history is output as `lk_local_idx` and selects a local counter. `lk_local_pred` is 1 when that counter is 2 or 3.
- R3: The 12-bit global history is output as `lk_global_idx` and selects a counter in the global table. `lk_global_pred` is 1 when that counter is 2 or 3.
- R4: The chooser counter at the global history index drives `lk_use_global`, which is 1 for values 2 and 3. `lk_pred` equals `lk_global_pred` when `lk_use_global` is 1 and `lk_local_pred` otherwise.
- R5: On a resolve, the local counter at `rs_local_idx` and the global counter at `rs_global_idx` each step up by one if taken and down by one if not, clamped to the range 0 to 3.
- R6: On a resolve, the chooser counter at `rs_global_idx` is unchanged when the two components' current counters at the resolve indices predict the same direction. Otherwise it steps up (clamped at 3) when the global component was right, and steps down (clamped at 0) when the local one was right.
- R7: On a resolve, the global history shifts left by one and takes the outcome into bit 0.
- R8: On a resolve, only the local history selected by `rs_pc[11:2]` shifts left and takes the outcome into bit 0. Branch addresses that share bits [11:2] share one history.
- R9: While `rs_valid` is 0, the resolve inputs have no effect on any history or counter.
- R10: A resolve becomes visible at the lookup outputs in the cycle after the clock edge that captures it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | 32 | Branch address to predict |
| lk_pred | output | 1 | Final direction, 1 means taken |
| lk_local_pred | output | 1 | Local component direction |
| lk_global_pred | output | 1 | Global component direction |
| lk_use_global | output | 1 | Chooser picked the global component |
| lk_local_idx | output | 10 | Local history used as local counter index |
| lk_global_idx | output | 12 | Global history used as global and chooser index |
| rs_valid | input | 1 | Resolve strobe |
| rs_pc | input | 32 | Address of the resolved branch |
| rs_taken | input | 1 | Real outcome of the resolved branch |
| rs_local_idx | input | 10 | Local index returned at lookup |
| rs_global_idx | input | 12 | Global index returned at lookup |

## Verification
A wrong counter or history appears at the lookup outputs in the cycle right after the resolve edge, but only if that same slot or index is looked up again. For that reason the stimulus revisits addresses, including two addresses that alias to one local slot. A chooser that trains when it should not shows up only later, as a wrong `lk_use_global` and therefore a wrong `lk_pred`, once enough outcomes have pushed it across the threshold at 2. The bench compares every lookup output against a model built from the requirements, on every step.

// File: rtl/tourney_bp.sv
module tourney_bp #(
  parameter int PC_W   = 32,
  parameter int PC_LO  = 2,
  parameter int SLOT_W = 10,
  parameter int LH_W   = 10,
  parameter int GH_W   = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_pred,
  output logic            lk_local_pred,
  output logic            lk_global_pred,
  output logic            lk_use_global,
  output logic [LH_W-1:0] lk_local_idx,
  output logic [GH_W-1:0] lk_global_idx,
  input  logic            rs_valid,
  input  logic [PC_W-1:0] rs_pc,
  input  logic            rs_taken,
  input  logic [LH_W-1:0] rs_local_idx,
  input  logic [GH_W-1:0] rs_global_idx
);
  localparam int SLOTS = 1 << SLOT_W;
  localparam int LSIZE = 1 << LH_W;
  localparam int GSIZE = 1 << GH_W;

  logic [LH_W-1:0] lhist [SLOTS];
  logic [1:0]      lctr  [LSIZE];
  logic [1:0]      gctr  [GSIZE];
  logic [1:0]      chsr  [GSIZE];
  logic [GH_W-1:0] ghist;

  function automatic logic [1:0] sat(input logic [1:0] c, input logic up);
    if (up) return (c == 2'd3) ? c : c + 2'd1;
    else    return (c == 2'd0) ? c : c - 2'd1;
  endfunction

  wire [SLOT_W-1:0] lk_slot = lk_pc[PC_LO +: SLOT_W];
  wire [SLOT_W-1:0] rs_slot = rs_pc[PC_LO +: SLOT_W];

  assign lk_local_idx   = lhist[lk_slot];
  assign lk_global_idx  = ghist;
  assign lk_local_pred  = lctr[lk_local_idx][1];
  assign lk_global_pred = gctr[ghist][1];
  assign lk_use_global  = chsr[ghist][1];
  assign lk_pred        = lk_use_global ? lk_global_pred : lk_local_pred;

  wire r_lp = lctr[rs_local_idx][1];
  wire r_gp = gctr[rs_global_idx][1];

  wire unused_pc_bits = ^{lk_pc[PC_W-1:PC_LO+SLOT_W], lk_pc[PC_LO-1:0],
                          rs_pc[PC_W-1:PC_LO+SLOT_W], rs_pc[PC_LO-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ghist <= '0;
      for (int i = 0; i < SLOTS; i++) lhist[i] <= '0;
      for (int i = 0; i < LSIZE; i++) lctr[i] <= 2'd1;
      for (int i = 0; i < GSIZE; i++) begin
        gctr[i] <= 2'd1;
        chsr[i] <= 2'd2;
      end
    end else if (rs_valid) begin
      ghist                <= {ghist[GH_W-2:0], rs_taken};
      lhist[rs_slot]       <= {lhist[rs_slot][LH_W-2:0], rs_taken};
      lctr[rs_local_idx]   <= sat(lctr[rs_local_idx], rs_taken);
      gctr[rs_global_idx]  <= sat(gctr[rs_global_idx], rs_taken);
      if (r_lp != r_gp)
        chsr[rs_global_idx] <= sat(chsr[rs_global_idx], r_gp == rs_taken);
    end
  end
endmodule

// File: rtl/tourney_bp_chk.sv
module tourney_bp_chk #(
  parameter int PC_W   = 32,
  parameter int PC_LO  = 2,
  parameter int SLOT_W = 10,
  parameter int LH_W   = 10,
  parameter int GH_W   = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PC_W-1:0] lk_pc,
  input logic            lk_pred,
  input logic            lk_local_pred,
  input logic            lk_global_pred,
  input logic [LH_W-1:0] lk_local_idx,
  input logic [GH_W-1:0] lk_global_idx,
  input logic            rs_valid,
  input logic [PC_W-1:0] rs_pc,
  input logic            rs_taken
);
  // R7
  ghist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid |=> lk_global_idx == {$past(lk_global_idx[GH_W-2:0]), $past(rs_taken)});

  // R9
  ghist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rs_valid |=> $stable(lk_global_idx));

  // R8
  lhist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && lk_pc[PC_LO +: SLOT_W] == rs_pc[PC_LO +: SLOT_W])
      ##1 (lk_pc[PC_LO +: SLOT_W] == $past(rs_pc[PC_LO +: SLOT_W]))
      |-> lk_local_idx == {$past(lk_local_idx[LH_W-2:0]), $past(rs_taken)});

  // R4
  pred_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_local_pred == lk_global_pred) |-> (lk_pred == lk_local_pred));
endmodule

bind tourney_bp tourney_bp_chk #(
  .PC_W(PC_W), .PC_LO(PC_LO), .SLOT_W(SLOT_W), .LH_W(LH_W), .GH_W(GH_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_pred(lk_pred),
  .lk_local_pred(lk_local_pred), .lk_global_pred(lk_global_pred),
  .lk_local_idx(lk_local_idx), .lk_global_idx(lk_global_idx),
  .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_taken(rs_taken)
);

// File: tb/tourney_bp_test.sv
module tourney_bp_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] lk_pc = '0;
  logic        lk_pred, lk_local_pred, lk_global_pred, lk_use_global;
  logic [9:0]  lk_local_idx;
  logic [11:0] lk_global_idx;
  logic        rs_valid = 0;
  logic [31:0] rs_pc = '0;
  logic        rs_taken = 0;
  logic [9:0]  rs_local_idx = '0;
  logic [11:0] rs_global_idx = '0;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tourney_bp uut (.*);

  logic [9:0]  m_lh [1024];
  logic [1:0]  m_lc [1024];
  logic [1:0]  m_gc [4096];
  logic [1:0]  m_ch [4096];
  logic [11:0] m_gh;

  localparam logic [32:0] VEC [24] = '{
    {32'h0000_0040, 1'b1}, {32'h0000_0080, 1'b0}, {32'h0000_0040, 1'b1},
    {32'h0000_0080, 1'b1}, {32'h0000_0040, 1'b1}, {32'h0000_0080, 1'b0},
    {32'h0000_0040, 1'b0}, {32'h0000_0080, 1'b1}, {32'h0000_1040, 1'b1},
    {32'h0000_0040, 1'b1}, {32'h0000_1040, 1'b0}, {32'h0000_0ffc, 1'b1},
    {32'h0000_0040, 1'b1}, {32'h0000_0ffc, 1'b1}, {32'h0000_0080, 1'b0},
    {32'h0000_0040, 1'b0}, {32'h0000_0ffc, 1'b0}, {32'h0000_0080, 1'b1},
    {32'h0000_1040, 1'b1}, {32'h0000_0040, 1'b1}, {32'h0000_0ffc, 1'b1},
    {32'h0000_0080, 1'b0}, {32'h0000_0040, 1'b1}, {32'h0000_0003, 1'b0}
  };

  function automatic logic [1:0] msat(input logic [1:0] c, input logic up);
    if (up) return (c == 2'd3) ? c : c + 2'd1;
    return (c == 2'd0) ? c : c - 2'd1;
  endfunction

  task automatic model_reset();
    m_gh = '0;
    for (int i = 0; i < 1024; i++) begin m_lh[i] = '0; m_lc[i] = 2'd1; end
    for (int i = 0; i < 4096; i++) begin m_gc[i] = 2'd1; m_ch[i] = 2'd2; end
  endtask

  task automatic chk(input string req, input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic check_lookup(input logic [31:0] pc, input string tag);
    logic [9:0] li;
    logic lp, gp, ug;
    li = m_lh[pc[11:2]];
    lp = m_lc[li][1];
    gp = m_gc[m_gh][1];
    ug = m_ch[m_gh][1];
    chk("R2", {tag, " local_idx"}, lk_local_idx, li);
    chk("R3", {tag, " global_idx"}, lk_global_idx, m_gh);
    chk("R5", {tag, " local_pred"}, lk_local_pred, lp);
    chk("R5", {tag, " global_pred"}, lk_global_pred, gp);
    chk("R6", {tag, " use_global"}, lk_use_global, ug);
    chk("R4", {tag, " pred"}, lk_pred, ug ? gp : lp);
  endtask

  // lookup, check, resolve; R10: checked in the cycle after the edge
  task automatic step(input logic [31:0] pc, input logic t);
    logic [9:0] li;
    logic lp, gp;
    @(negedge clk);
    lk_pc = pc;
    #2;
    check_lookup(pc, "step");
    li = m_lh[pc[11:2]];
    lp = m_lc[li][1];
    gp = m_gc[m_gh][1];
    rs_valid = 1; rs_pc = pc; rs_taken = t;
    rs_local_idx = li; rs_global_idx = m_gh;
    @(posedge clk);
    #1 rs_valid = 0;
    m_lc[li] = msat(m_lc[li], t);
    m_gc[m_gh] = msat(m_gc[m_gh], t);
    if (lp != gp) m_ch[m_gh] = msat(m_ch[m_gh], gp == t);
    m_lh[pc[11:2]] = {m_lh[pc[11:2]][8:0], t};
    m_gh = {m_gh[10:0], t};
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    lk_pc = 32'h40;
    #2;
    // R1 reset state
    chk("R1", "pred", lk_pred, 0);
    chk("R1", "local_pred", lk_local_pred, 0);
    chk("R1", "global_pred", lk_global_pred, 0);
    chk("R1", "use_global", lk_use_global, 1);
    chk("R1", "local_idx", lk_local_idx, 0);
    chk("R1", "global_idx", lk_global_idx, 0);

    // R6: both agree not-taken and are right -> chooser still selects global
    step(32'h40, 1'b0);
    @(negedge clk); lk_pc = 32'h40; #2;
    chk("R6", "use_global after agree", lk_use_global, 1);
    chk("R5", "global counter floor", lk_global_pred, 0);

    for (int pass = 0; pass < 4; pass++)
      for (int k = 0; k < 24; k++) step(VEC[k][32:1], VEC[k][0]);

    // R5 saturation: hammer one branch taken
    for (int k = 0; k < 20; k++) step(32'h200, 1'b1);
    @(negedge clk); lk_pc = 32'h200; #2;
    chk("R5", "saturated local taken", lk_local_pred, 1);
    chk("R7", "ghist all ones", lk_global_idx, 12'hfff);
    chk("R8", "lhist all ones", lk_local_idx, 10'h3ff);
    for (int k = 0; k < 3; k++) step(32'h200, 1'b0);
    check_lookup(32'h200, "after NT");

    // R9: resolve inputs wiggle with rs_valid low
    @(negedge clk);
    rs_valid = 0; rs_pc = 32'h200; rs_taken = 1;
    rs_local_idx = lk_local_idx; rs_global_idx = lk_global_idx;
    repeat (3) @(posedge clk);
    @(negedge clk); lk_pc = 32'h200; #2;
    check_lookup(32'h200, "R9 idle");
    chk("R9", "ghist held", lk_global_idx, m_gh);

    // R8 aliasing: 0x1040 and 0x40 share one history slot
    step(32'h1040, 1'b1);
    @(negedge clk); lk_pc = 32'h40; #2;
    chk("R8", "alias shares history", lk_local_idx, m_lh[10'h010]);

    // R1 again after a mid-run reset
    @(negedge clk); rst_n = 0;
    @(posedge clk); #1 rst_n = 1;
    model_reset();
    @(negedge clk); lk_pc = 32'h200; #2;
    chk("R1", "re-reset global_idx", lk_global_idx, 0);
    chk("R1", "re-reset local_idx", lk_local_idx, 0);
    chk("R1", "re-reset use_global", lk_use_global, 1);
    chk("R1", "re-reset pred", lk_pred, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule